// File: doc/BRIEF.md
# Linked-List Quad-SPI DMA Sequencer

This block moves data between system memory and a half-duplex quad-SPI serial engine. The work comes from a chain of descriptors in memory, not from a single address and length pair. Software enables the engine and writes the address of the first descriptor to the start register. The sequencer then reads that descriptor's three words over a 32-bit memory read/write port. It streams the segment's bytes in the direction the descriptor gives, and follows the next-descriptor link until the link is zero.

Each segment carries its own lane mode, which is presented to the serial engine. Each segment also carries a keep-select flag, which decides whether chip select stays asserted into the next segment. Bytes cross to the serial engine through a valid/ready handshake in each direction. Pin shifting and serial clocking belong to the engine.

Completion of the chain, bus error responses and misaligned buffers are reported in a write-one-to-clear status register. The enabled status bits are ORed onto an interrupt line.

Top module: `qspi_desc_dma`

## Requirements
- R1: After reset the status, current-descriptor and current-data-address registers read 0. Chip select, the interrupt and the memory request are all low.
- R2: A write to offset 0x40 starts a chain at the written address only if configuration bit 0 (offset 0x00) is 1 and no chain is running. The descriptor address must be word aligned. A start write while disabled or while busy is ignored. The three descriptor words are read from A, A+4 and A+8, in the order buffer address, next-descriptor address, control word.
- R3: Control word fields: bit 0 is the direction (1 = memory to device, 0 = device to memory), bits 3:1 are the lane mode, bit 8 is the keep-select flag and bits 31:16 are the byte count. The lane mode appears on `laneMode` for every byte of that segment, and `dirWrite` equals bit 0.
- R4: In the memory-to-device direction, bytes go out on the tx handshake in ascending address order. Byte k of a memory word comes from bits 8k+7:8k.
- R5: In the device-to-memory direction, received bytes are packed little-endian into words and written with byte enables. Bytes beyond the segment length in its last word are not modified.
- R6: Chip select is asserted for every byte moved. It stays asserted after a segment whose keep-select flag is 1. It is released after a segment whose flag is 0, and on any abort.
- R7: A next-descriptor address of zero ends the chain. Any other value causes that descriptor to be fetched after the current segment.
- R8: A zero-length segment causes no data access and no byte handshake. Its buffer alignment is not checked.
- R9: Status bit 31 (offset 0x08) is set at chain end only if enable bit 31 (offset 0x0C) is 1. Writing ones to status bits clears them. `irq` is the OR of status ANDed with enable.
- R10: A non-empty segment whose buffer address has any of bits 4:0 set aborts the chain before any data access and sets status bit 2.
- R11: An error response on any memory access aborts the chain at once and sets status bit 1.
- R12: Offset 0x44 reads the current descriptor address. Offset 0x48 reads the current data address, which starts at the buffer address and advances by 4 for every word finished, including a partial last word.
- R13: Clearing configuration bit 0 while a chain runs lets the current segment finish. No further descriptor is fetched, chip select is released and status bit 31 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Byte enables for writes |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access complete |
| memErr | input | 1 | Error response, valid with memAck |
| txValid | output | 1 | Byte to serial engine valid |
| txReady | input | 1 | Serial engine accepts byte |
| txByte | output | 8 | Byte to serial engine |
| rxValid | input | 1 | Byte from serial engine valid |
| rxReady | output | 1 | Sequencer accepts received byte |
| rxByte | input | 8 | Byte from serial engine |
| laneMode | output | 3 | Lane mode of the current segment |
| dirWrite | output | 1 | Current segment direction, 1 = to device |
| csAssert | output | 1 | Chip select request, active high |
| irq | output | 1 | Interrupt |

## Verification
The bench targets a two-segment chain that crosses directions while keep-select is set. A sequencer that dropped chip select between segments would show two release edges instead of one. A read segment of five bytes checks byte-enable handling: a block that wrote whole words would overwrite the guard byte after the fifth. A zero-length segment with a misaligned buffer must produce only descriptor fetches, so a wrong ordering of checks would raise an alignment error or touch memory. Bus errors, disabled completion reporting, start writes while idle-disabled or busy, and disabling in mid-chain are each driven, and the exact number of memory accesses is counted to expose extra or missing traffic.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  // register offsets (byte)
  localparam int REG_CFG  = 'h00;
  localparam int REG_STS  = 'h08;
  localparam int REG_IEN  = 'h0C;
  localparam int REG_NEXT = 'h40;
  localparam int REG_CUR  = 'h44;
  localparam int REG_MEM  = 'h48;

  // status bit positions
  localparam int STS_BUSERR = 1;
  localparam int STS_ALIGN  = 2;
  localparam int STS_DONE   = 31;

  // control word field positions
  localparam int CW_DIR  = 0;
  localparam int CW_LANE = 1;
  localparam int CW_FRAG = 8;
  localparam int CW_LEN  = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_MRD, S_TXB, S_RXB, S_MWR, S_SEGEND
  } seqState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic busy;
    logic fetching;
    logic start;
    logic capWord;
    logic segInit;
    logic loadBuf;
    logic byteTx;
    logic byteRx;
    logic wordDone;
    logic advance;
    logic csRelease;
    logic chainDone;
    logic busErr;
    logic alignErr;
  } dpStrobe_t;
endpackage

// File: rtl/qdma_ctrl.sv
module qdma_ctrl
  import qdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       dmaEn,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       fetchLast,
  input  logic       lenZero,
  input  logic       misaligned,
  input  logic       dirWr,
  input  logic       fragment,
  input  logic       nextZero,
  input  logic       remainOne,
  input  logic       remainZero,
  input  logic       byteLast,
  input  logic       txReady,
  input  logic       rxValid,
  output dpStrobe_t  stb,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       rxReady
);
  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    stb     = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txValid = 1'b0;
    rxReady = 1'b0;
    stb.busy = (stateQ != S_IDLE);
    case (stateQ)
      S_IDLE: begin
        if (startReq) begin
          stb.start = 1'b1;
          stateD = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.fetching = 1'b1;
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            stb.busErr = 1'b1;
            stb.csRelease = 1'b1;
            stateD = S_IDLE;
          end else begin
            stb.capWord = 1'b1;
            if (fetchLast) stateD = S_DECIDE;
          end
        end
      end
      S_DECIDE: begin
        if (lenZero) stateD = S_SEGEND;
        else if (misaligned) begin
          stb.alignErr = 1'b1;
          stb.csRelease = 1'b1;
          stateD = S_IDLE;
        end else begin
          stb.segInit = 1'b1;
          stateD = dirWr ? S_MRD : S_RXB;
        end
      end
      S_MRD: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            stb.busErr = 1'b1;
            stb.csRelease = 1'b1;
            stateD = S_IDLE;
          end else begin
            stb.loadBuf = 1'b1;
            stateD = S_TXB;
          end
        end
      end
      S_TXB: begin
        txValid = 1'b1;
        if (txReady) begin
          stb.byteTx = 1'b1;
          if (remainOne) begin
            stb.wordDone = 1'b1;
            stateD = S_SEGEND;
          end else if (byteLast) begin
            stb.wordDone = 1'b1;
            stateD = S_MRD;
          end
        end
      end
      S_RXB: begin
        rxReady = 1'b1;
        if (rxValid) begin
          stb.byteRx = 1'b1;
          if (remainOne || byteLast) stateD = S_MWR;
        end
      end
      S_MWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (memErr) begin
            stb.busErr = 1'b1;
            stb.csRelease = 1'b1;
            stateD = S_IDLE;
          end else begin
            stb.wordDone = 1'b1;
            stateD = remainZero ? S_SEGEND : S_RXB;
          end
        end
      end
      S_SEGEND: begin
        if (!fragment) stb.csRelease = 1'b1;
        if (nextZero) begin
          stb.chainDone = 1'b1;
          stateD = S_IDLE;
        end else if (!dmaEn) begin
          stb.csRelease = 1'b1;
          stateD = S_IDLE;
        end else begin
          stb.advance = 1'b1;
          stateD = S_FETCH;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  // R11
  memHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R4
  oneDirection_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && rxReady));
endmodule

// File: rtl/qdma_datapath.sv
module qdma_datapath
  import qdma_pkg::*;
#(
  parameter int REG_AW     = 8,
  parameter int LEN_W      = 16,
  parameter int ALIGN_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        rxByte,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic [7:0]        txByte,
  output logic [2:0]        laneMode,
  output logic              dirWr,
  output logic              csAssert,
  output logic              irq,
  output logic              startReq,
  output logic              dmaEn,
  output logic              fetchLast,
  output logic              lenZero,
  output logic              misaligned,
  output logic              fragment,
  output logic              nextZero,
  output logic              remainOne,
  output logic              remainZero,
  output logic              byteLast
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic              cfgEn;
  logic [31:0]       intEn, intSts, setMask, clrMask;
  logic [31:0]       curDesc, bufAddr, nextAddr, memPtr, wordBuf;
  logic              dirBit, fragBit, csReg;
  logic [2:0]        laneBits;
  logic [LEN_W-1:0]  lenField, remain;
  logic [1:0]        fetchIdx, byteIdx;
  logic [3:0]        byteEn;

  always_comb begin
    setMask = '0;
    setMask[STS_DONE]   = stb.chainDone & intEn[STS_DONE];
    setMask[STS_BUSERR] = stb.busErr;
    setMask[STS_ALIGN]  = stb.alignErr;
    clrMask = (regWe && regAddr == REG_AW'(REG_STS)) ? regWdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn <= 1'b0; intEn <= '0; intSts <= '0;
      curDesc <= '0; bufAddr <= '0; nextAddr <= '0; memPtr <= '0; wordBuf <= '0;
      dirBit <= 1'b0; fragBit <= 1'b0; csReg <= 1'b0; laneBits <= '0;
      lenField <= '0; remain <= '0; fetchIdx <= '0; byteIdx <= '0; byteEn <= '0;
    end else begin
      if (regWe && regAddr == REG_AW'(REG_CFG)) cfgEn <= regWdata[0];
      if (regWe && regAddr == REG_AW'(REG_IEN)) intEn <= regWdata;
      intSts <= (intSts & ~clrMask) | setMask;
      if (stb.start) begin
        curDesc  <= regWdata;
        fetchIdx <= '0;
      end
      if (stb.capWord) begin
        case (fetchIdx)
          2'd0: bufAddr  <= memRdata;
          2'd1: nextAddr <= memRdata;
          default: begin
            dirBit   <= memRdata[CW_DIR];
            laneBits <= memRdata[CW_LANE +: 3];
            fragBit  <= memRdata[CW_FRAG];
            lenField <= memRdata[CW_LEN +: LEN_W];
          end
        endcase
        fetchIdx <= fetchIdx + 2'd1;
      end
      if (stb.advance) begin
        curDesc  <= nextAddr;
        fetchIdx <= '0;
      end
      if (stb.segInit) begin
        memPtr  <= bufAddr;
        remain  <= lenField;
        byteIdx <= '0;
        byteEn  <= '0;
        csReg   <= 1'b1;
      end
      if (stb.loadBuf) wordBuf <= memRdata;
      if (stb.byteTx) begin
        remain  <= remain - LEN_ONE;
        byteIdx <= byteIdx + 2'd1;
      end
      if (stb.byteRx) begin
        wordBuf[byteIdx*8 +: 8] <= rxByte;
        byteEn[byteIdx] <= 1'b1;
        remain  <= remain - LEN_ONE;
        byteIdx <= byteIdx + 2'd1;
      end
      if (stb.wordDone) begin
        memPtr  <= memPtr + 32'd4;
        byteIdx <= '0;
        byteEn  <= '0;
      end
      if (stb.csRelease) csReg <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      REG_AW'(REG_CFG): regRdata = {31'b0, cfgEn};
      REG_AW'(REG_STS): regRdata = intSts;
      REG_AW'(REG_IEN): regRdata = intEn;
      REG_AW'(REG_CUR): regRdata = curDesc;
      REG_AW'(REG_MEM): regRdata = memPtr;
      default:          regRdata = '0;
    endcase
  end

  assign startReq   = regWe && (regAddr == REG_AW'(REG_NEXT)) && cfgEn && !stb.busy;
  assign dmaEn      = cfgEn;
  assign memAddr    = stb.fetching ? (curDesc + 32'({fetchIdx, 2'b00})) : memPtr;
  assign memWdata   = wordBuf;
  assign memBe      = byteEn;
  assign txByte     = wordBuf[byteIdx*8 +: 8];
  assign laneMode   = laneBits;
  assign dirWr      = dirBit;
  assign csAssert   = csReg;
  assign irq        = |(intSts & intEn);
  assign fetchLast  = (fetchIdx == 2'd2);
  assign lenZero    = (lenField == '0);
  assign misaligned = |bufAddr[ALIGN_LOG2-1:0];
  assign fragment   = fragBit;
  assign nextZero   = (nextAddr == '0);
  assign remainOne  = (remain == LEN_ONE);
  assign remainZero = (remain == '0);
  assign byteLast   = (byteIdx == 2'd3);

  // R9
  doneNeedsEnable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intSts[STS_DONE]) |-> $past(intEn[STS_DONE]));

  // R5
  noUnderflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.byteTx || stb.byteRx) |-> (remain != '0));
endmodule

// File: rtl/qspi_desc_dma.sv
module qspi_desc_dma
  import qdma_pkg::*;
#(
  parameter int REG_AW     = 8,
  parameter int LEN_W      = 16,
  parameter int ALIGN_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txByte,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxByte,
  output logic [2:0]        laneMode,
  output logic              dirWrite,
  output logic              csAssert,
  output logic              irq
);
  dpStrobe_t stb;
  logic startReq, dmaEn, fetchLast, lenZero, misaligned, fragment;
  logic nextZero, remainOne, remainZero, byteLast;

  qdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dmaEn(dmaEn),
    .memAck(memAck), .memErr(memErr), .fetchLast(fetchLast), .lenZero(lenZero),
    .misaligned(misaligned), .dirWr(dirWrite), .fragment(fragment),
    .nextZero(nextZero), .remainOne(remainOne), .remainZero(remainZero),
    .byteLast(byteLast), .txReady(txReady), .rxValid(rxValid), .stb(stb),
    .memReq(memReq), .memWe(memWe), .txValid(txValid), .rxReady(rxReady)
  );

  qdma_datapath #(.REG_AW(REG_AW), .LEN_W(LEN_W), .ALIGN_LOG2(ALIGN_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memRdata(memRdata), .rxByte(rxByte),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .txByte(txByte),
    .laneMode(laneMode), .dirWr(dirWrite), .csAssert(csAssert), .irq(irq),
    .startReq(startReq), .dmaEn(dmaEn), .fetchLast(fetchLast), .lenZero(lenZero),
    .misaligned(misaligned), .fragment(fragment), .nextZero(nextZero),
    .remainOne(remainOne), .remainZero(remainZero), .byteLast(byteLast)
  );

  // R6
  csDuringData_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || rxReady) |-> csAssert);
endmodule

// File: tb/qspi_desc_dma_bench.sv
module qspi_desc_dma_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        txValid, txReady = 1'b0;
  logic [7:0]  txByte;
  logic        rxValid = 1'b0, rxReady;
  logic [7:0]  rxByte = '0;
  logic [2:0]  laneMode;
  logic        dirWrite, csAssert, irq;

  qspi_desc_dma u_qspi_desc_dma (.*);

  int nChecks = 0, nFails = 0;
  logic [31:0] mem [0:255];
  int accCount = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFC;
  logic [10:0] expQ [$];
  logic [7:0]  rxQ [$];
  logic [2:0]  expRxLane = '0;
  int csFalls = 0;
  logic csPrev = 1'b0;
  int txPace = 0;
  logic [31:0] rd;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      memErr = 1'b0;
    end else if (memReq && rstN) begin
      accCount++;
      memErr = (memAddr == errAddr);
      if (memWe && !memErr)
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] = memWdata[8*b +: 8];
      memRdata = mem[memAddr[9:2]];
      memAck = 1'b1;
    end
  end

  // tx monitor: pops the scoreboard
  always @(negedge clk) begin
    txPace++;
    txReady = (txPace % 3) != 1;
    #1;
    if (txValid && txReady) begin
      if (expQ.size() == 0) check(1'b0, "R4", "unexpected tx byte", {24'b0, txByte}, 32'h0);
      else begin
        logic [10:0] item;
        item = expQ.pop_front();
        check({laneMode, txByte} == item && dirWrite, "R4/R3", "tx lane,byte",
              {21'b0, laneMode, txByte}, {21'b0, item});
      end
    end
  end

  // rx source
  always @(negedge clk) begin
    rxValid = (rxQ.size() != 0);
    rxByte  = rxValid ? rxQ[0] : 8'h00;
    #1;
    if (rxValid && rxReady) begin
      void'(rxQ.pop_front());
      check(laneMode == expRxLane && !dirWrite, "R3", "rx lane/dir",
            {28'b0, dirWrite, laneMode}, {29'b0, expRxLane});
    end
  end

  // chip select release counter
  always @(negedge clk) begin
    if (csPrev && !csAssert) csFalls++;
    csPrev = csAssert;
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic putDesc(input logic [31:0] at, input logic [31:0] bufA,
                         input logic [31:0] nxt, input bit dir, input logic [2:0] lane,
                         input bit frag, input logic [15:0] len);
    mem[at[9:2]]     = bufA;
    mem[at[9:2] + 1] = nxt;
    mem[at[9:2] + 2] = {len, 7'b0, frag, 4'b0, lane, dir};
  endtask

  // driver: push expected tx bytes
  task automatic expectTx(input logic [31:0] bufA, input int len, input logic [2:0] lane);
    for (int i = 0; i < len; i++) begin
      logic [31:0] a;
      a = bufA + 32'(i);
      expQ.push_back({lane, mem[a[9:2]][8*a[1:0] +: 8]});
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    waitCycles(3);
    rstN = 1'b1;
    // R1 reset state
    check(!csAssert && !irq && !memReq, "R1", "cs/irq/req after reset",
          {29'b0, csAssert, irq, memReq}, 32'h0);
    regRead(8'h08, rd); check(rd == 32'h0, "R1", "status", rd, 32'h0);
    regRead(8'h44, rd); check(rd == 32'h0, "R1", "current descriptor", rd, 32'h0);
    regRead(8'h48, rd); check(rd == 32'h0, "R1", "current data address", rd, 32'h0);

    // R2 start while disabled is ignored
    putDesc(32'h100, 32'h200, 32'h120, 1'b1, 3'd2, 1'b1, 16'd6);
    regWrite(8'h40, 32'h100);
    waitCycles(20);
    check(accCount == 0, "R2", "accesses while disabled", accCount, 0);

    // two-segment chain, write then read, keep-select on first
    regWrite(8'h00, 32'h1);
    regWrite(8'h0C, 32'h8000_0006);
    mem[8'h80] = 32'h4433_2211; mem[8'h81] = 32'h8877_6655;
    putDesc(32'h120, 32'h240, 32'h0, 1'b0, 3'd3, 1'b0, 16'd5);
    mem[8'h90] = 32'hEEEE_EEEE; mem[8'h91] = 32'hEEEE_EEEE;
    expectTx(32'h200, 6, 3'd2);
    rxQ = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
    expRxLane = 3'd3;
    accCount = 0; csFalls = 0;
    regWrite(8'h40, 32'h100);
    waitCycles(2);
    regWrite(8'h40, 32'h1C0);          // R2 ignored while busy
    waitCycles(300);
    check(expQ.size() == 0, "R4", "tx bytes left", expQ.size(), 0);
    check(rxQ.size() == 0, "R5", "rx bytes left", rxQ.size(), 0);
    check(mem[8'h90] == 32'hD4C3_B2A1, "R5", "full rx word", mem[8'h90], 32'hD4C3_B2A1);
    check(mem[8'h91] == 32'hEEEE_EEE5, "R5", "partial rx word", mem[8'h91], 32'hEEEE_EEE5);
    check(csFalls == 1, "R6", "cs releases across keep-select chain", csFalls, 1);
    check(!csAssert, "R6", "cs after chain", {31'b0, csAssert}, 0);
    check(accCount == 10, "R7", "accesses for chain", accCount, 10);
    regRead(8'h08, rd); check(rd == 32'h8000_0000, "R9", "done status", rd, 32'h8000_0000);
    check(irq, "R9", "irq on done", {31'b0, irq}, 1);
    regRead(8'h44, rd); check(rd == 32'h120, "R12", "last descriptor / R2 busy start", rd, 32'h120);
    regRead(8'h48, rd); check(rd == 32'h248, "R12", "data address", rd, 32'h248);

    // R9 write one to clear
    regWrite(8'h08, 32'h8000_0006);
    regRead(8'h08, rd); check(rd == 32'h0, "R9", "status after clear", rd, 32'h0);
    check(!irq, "R9", "irq after clear", {31'b0, irq}, 0);

    // R8 zero-length segment with misaligned buffer skipped
    putDesc(32'h140, 32'h203, 32'h160, 1'b1, 3'd1, 1'b0, 16'd0);
    putDesc(32'h160, 32'h260, 32'h0, 1'b1, 3'd1, 1'b0, 16'd1);
    mem[8'h98] = 32'h0000_005A;
    expectTx(32'h260, 1, 3'd1);
    accCount = 0;
    regWrite(8'h40, 32'h140);
    waitCycles(200);
    check(accCount == 7, "R8", "accesses with empty segment", accCount, 7);
    regRead(8'h08, rd); check(rd == 32'h8000_0000, "R8", "no alignment error", rd, 32'h8000_0000);
    check(expQ.size() == 0, "R8", "tx bytes left", expQ.size(), 0);
    regWrite(8'h08, 32'hFFFF_FFFF);

    // R10 misaligned buffer
    putDesc(32'h180, 32'h208, 32'h0, 1'b1, 3'd1, 1'b0, 16'd4);
    accCount = 0;
    regWrite(8'h40, 32'h180);
    waitCycles(100);
    regRead(8'h08, rd); check(rd == 32'h4, "R10", "alignment status", rd, 32'h4);
    check(accCount == 3, "R10", "accesses", accCount, 3);
    check(irq && !csAssert, "R10", "irq set, cs low", {30'b0, irq, csAssert}, 32'h2);
    regWrite(8'h08, 32'hFFFF_FFFF);

    // R11 bus error on descriptor fetch
    putDesc(32'h1A0, 32'h2E0, 32'h0, 1'b1, 3'd1, 1'b0, 16'd4);
    errAddr = 32'h1A4;
    accCount = 0;
    regWrite(8'h40, 32'h1A0);
    waitCycles(100);
    errAddr = 32'hFFFF_FFFC;
    regRead(8'h08, rd); check(rd == 32'h2, "R11", "bus error status", rd, 32'h2);
    check(accCount == 2, "R11", "accesses", accCount, 2);
    regWrite(8'h08, 32'hFFFF_FFFF);

    // R9 done not reported when its enable is clear; R3 lane 4
    regWrite(8'h0C, 32'h0000_0006);
    putDesc(32'h1C0, 32'h280, 32'h0, 1'b1, 3'd4, 1'b0, 16'd2);
    mem[8'hA0] = 32'h0000_BBAA;
    expectTx(32'h280, 2, 3'd4);
    regWrite(8'h40, 32'h1C0);
    waitCycles(150);
    regRead(8'h08, rd); check(rd == 32'h0, "R9", "done masked", rd, 32'h0);
    check(!irq, "R9", "no irq", {31'b0, irq}, 0);
    check(expQ.size() == 0, "R3", "tx bytes left", expQ.size(), 0);

    // R13 disable in mid-chain
    regWrite(8'h0C, 32'h8000_0006);
    putDesc(32'h1E0, 32'h2A0, 32'h300, 1'b1, 3'd1, 1'b1, 16'd4);
    putDesc(32'h300, 32'h2C0, 32'h0, 1'b1, 3'd1, 1'b0, 16'd4);
    mem[8'hA8] = 32'h0D0C_0B0A;
    expectTx(32'h2A0, 4, 3'd1);
    accCount = 0;
    regWrite(8'h40, 32'h1E0);
    regWrite(8'h00, 32'h0);
    waitCycles(200);
    check(accCount == 4, "R13", "no further fetch", accCount, 4);
    regRead(8'h08, rd); check(rd == 32'h0, "R13", "no done status", rd, 32'h0);
    check(!csAssert, "R13", "cs released", {31'b0, csAssert}, 0);
    check(expQ.size() == 0, "R13", "segment finished", expQ.size(), 0);
    regRead(8'h44, rd); check(rd == 32'h1E0, "R13", "descriptor not advanced", rd, 32'h1E0);

    finishRun();
  end
endmodule